// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial frames from a line that idles high. A sample-rate enable from outside the block arrives eight times per bit period. The block sees a low line and treats it as a possible start bit. It confirms the start only if the line stays low until the middle of that bit. A glitch that returns high earlier sends the controller back to waiting. Once the start is confirmed, the block samples the line once per bit period at mid-bit. It shifts eight data bits in least-significant bit first, then samples one stop bit.

When the stop bit has been sampled, the word moves from the shift register to a data register that the host reads. A one-clock valid pulse marks the transfer. Two sticky flags are set at the same moment:
- an overrun flag, set when the host reports through its not-ready input that it cannot take the word;
- a framing flag, set when the stop sample is low.

Both flags stay set until the next start edge is seen. The controller has three states:
- `ST_IDLE`, waiting for a low sample;
- `ST_START`, checking the start bit;
- `ST_RECV`, sampling data and stop bits.

The transitions are:
- idle to start on a low sample;
- start back to idle on a high sample (false start);
- start to receive on the fourth consecutive low sample;
- receive to idle on the stop sample.

Line synchronisation and generation of the sample enable are handled outside the block.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_valid` is 0 and both error flags are 0.
- R2: While `rx_line` is 1 on every sample tick, no word is produced.
- R3: If the line returns to 1 on any of the first four start samples (index 0 to 3), the controller goes back to idle and produces no word. A frame that follows is received correctly.
- R4: The start bit is confirmed on its fourth consecutive low sample (index 3 of 0..7). Each data bit is then sampled exactly 8 ticks after the previous sample. The first data bit received goes to `rx_data[0]`.
- R5: `rx_valid` is high for exactly one clock per completed frame. That clock follows the clock edge at which the stop bit is sampled.
- R6: `err_frame` is set when the stop sample is 0, and the word is still loaded into `rx_data`. A stop sample of 1 leaves `err_frame` at 0.
- R7: `err_overrun` takes the value of `host_busy` at the stop-sample tick.
- R8: Both error flags hold their value until the first low sample in idle, and they are 0 from the following clock onward.
- R9: Without `smp_tick`, the line has no effect on the receiver's state.
- R10: `rx_data` changes only in the clock in which `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | Sample enable, 8 per bit period |
| rx_line | input | 1 | Serial input, already synchronised, idles high |
| host_busy | input | 1 | Host not ready to accept a word |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | One-clock pulse when `rx_data` is loaded |
| err_overrun | output | 1 | Host was busy when the word completed |
| err_frame | output | 1 | Stop bit was sampled low |

## Verification
The bench sends frames whose data bits hold the bit value only at sample index 3 and the complement at the other seven indices. A receiver that samples off mid-bit, or that confirms the start one tick early or late, therefore returns a corrupted word. Two false starts are sent: one of two low samples and one of three low samples. A design that confirms the start too early would frame random data out of the idle line, and a design that has not learned to fall back would miss the frame that follows. A long low level is held with the tick off to expose a receiver that advances on the clock rather than on the enable. Error flags are checked both to persist across idle ticks and to clear on the next start edge, which catches flags that are overwritten too early or never released.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/osr_rx_counter.sv
module osr_rx_counter #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + WIDTH'(1);
    end
endmodule

// File: rtl/osr_rx_ctrl.sv
module osr_rx_ctrl
    import osr_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_tick,
    input  logic      rx_line,
    input  logic      smp_at_mid,
    input  logic      smp_at_end,
    input  logic      bit_at_stop,
    output rx_state_e state,
    output logic      smp_clr,
    output logic      smp_inc,
    output logic      bit_clr,
    output logic      bit_inc,
    output logic      shift_en,
    output logic      load_en,
    output logic      frame_open
);
    rx_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d    = state;
        smp_clr    = 1'b0;
        smp_inc    = 1'b0;
        bit_clr    = 1'b0;
        bit_inc    = 1'b0;
        shift_en   = 1'b0;
        load_en    = 1'b0;
        frame_open = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (smp_tick && !rx_line) begin
                    state_d    = ST_START;
                    smp_clr    = 1'b1;
                    bit_clr    = 1'b1;
                    frame_open = 1'b1;
                end
            end
            ST_START: begin
                if (smp_tick) begin
                    if (rx_line) begin
                        state_d = ST_IDLE;
                        smp_clr = 1'b1;
                    end else if (smp_at_mid) begin
                        state_d = ST_RECV;
                        smp_clr = 1'b1;
                        bit_clr = 1'b1;
                    end else begin
                        smp_inc = 1'b1;
                    end
                end
            end
            ST_RECV: begin
                if (smp_tick) begin
                    if (smp_at_end) begin
                        smp_clr = 1'b1;
                        if (bit_at_stop) begin
                            load_en = 1'b1;
                            state_d = ST_IDLE;
                        end else begin
                            shift_en = 1'b1;
                            bit_inc  = 1'b1;
                        end
                    end else begin
                        smp_inc = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/osr_rx_datapath.sv
module osr_rx_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              host_busy,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic              frame_open,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_overrun,
    output logic              err_frame
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (shift_en)
            shreg <= {rx_line, shreg[DATA_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            err_overrun <= 1'b0;
            err_frame   <= 1'b0;
        end else begin
            rx_valid <= load_en;
            if (load_en) begin
                rx_data     <= shreg;
                err_overrun <= host_busy;
                err_frame   <= ~rx_line;
            end else if (frame_open) begin
                err_overrun <= 1'b0;
                err_frame   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_rx_pkg::*;
#(
    parameter int OSR    = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic              rx_line,
    input  logic              host_busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_overrun,
    output logic              err_frame
);
    localparam int SMP_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W + 1);
    // counter value on the tick that confirms the start bit (mid index OSR/2-1)
    localparam logic [SMP_W-1:0] SMP_MID = SMP_W'(OSR / 2 - 2);
    localparam logic [SMP_W-1:0] SMP_END = SMP_W'(OSR - 1);
    localparam logic [BIT_W-1:0] BIT_STOP = BIT_W'(DATA_W);

    rx_state_e        state_q;
    logic [SMP_W-1:0] smp_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic smp_clr, smp_inc, bit_clr, bit_inc;
    logic shift_en, load_en, frame_open;

    osr_rx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_tick   (smp_tick),
        .rx_line    (rx_line),
        .smp_at_mid (smp_cnt == SMP_MID),
        .smp_at_end (smp_cnt == SMP_END),
        .bit_at_stop(bit_cnt == BIT_STOP),
        .state      (state_q),
        .smp_clr    (smp_clr),
        .smp_inc    (smp_inc),
        .bit_clr    (bit_clr),
        .bit_inc    (bit_inc),
        .shift_en   (shift_en),
        .load_en    (load_en),
        .frame_open (frame_open)
    );

    osr_rx_counter #(.WIDTH(SMP_W)) u_smp_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (smp_clr),
        .inc  (smp_inc),
        .cnt  (smp_cnt)
    );

    osr_rx_counter #(.WIDTH(BIT_W)) u_bit_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (bit_clr),
        .inc  (bit_inc),
        .cnt  (bit_cnt)
    );

    osr_rx_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line    (rx_line),
        .host_busy  (host_busy),
        .shift_en   (shift_en),
        .load_en    (load_en),
        .frame_open (frame_open),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .err_overrun(err_overrun),
        .err_frame  (err_frame)
    );
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk
    import osr_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_tick,
    input logic              rx_line,
    input logic              host_busy,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              err_overrun,
    input logic              err_frame,
    input rx_state_e         state
);
    // R5: valid is a single-clock pulse
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: valid only follows a tick taken in the receive state
    p_valid_after_recv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(state) == ST_RECV && $past(smp_tick) && state == ST_IDLE));

    // R6: framing flag reflects the stop sample
    p_frame_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (err_frame == !$past(rx_line)));

    // R7: overrun flag reflects host readiness at the stop sample
    p_overrun_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (err_overrun == $past(host_busy)));

    // R8: flags released on a start edge seen in idle
    p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && smp_tick && !rx_line) |=> (!err_frame && !err_overrun));

    // R9: no state change without a sample tick
    p_tick_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_tick |=> $stable(state));

    // R10: data register only changes with the valid pulse
    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_data));
endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_tick   (smp_tick),
    .rx_line    (rx_line),
    .host_busy  (host_busy),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .err_overrun(err_overrun),
    .err_frame  (err_frame),
    .state      (state_q)
);

// File: tb/osr_uart_rx_test.sv
module osr_uart_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       host_busy = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       err_overrun;
    logic       err_frame;

    int total = 0;
    int bad = 0;
    int vcnt = 0;
    logic [7:0] cap_data = '0;
    logic cap_ovr = 1'b0;
    logic cap_frm = 1'b0;
    logic v_at = 1'b0;
    logic v_nx = 1'b0;
    bit done = 1'b0;

    // {data, stop bit value, host busy}
    localparam logic [9:0] VEC [5] = '{
        {8'hA5, 1'b1, 1'b0},
        {8'h00, 1'b1, 1'b0},
        {8'hFF, 1'b1, 1'b1},
        {8'h3C, 1'b0, 1'b0},
        {8'h81, 1'b0, 1'b1}
    };

    always #4 clk = ~clk;

    osr_uart_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_tick   (smp_tick),
        .rx_line    (rx_line),
        .host_busy  (host_busy),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .err_overrun(err_overrun),
        .err_frame  (err_frame)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcnt++;
            cap_data = rx_data;
            cap_ovr = err_overrun;
            cap_frm = err_frame;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_tick(input logic v);
        @(negedge clk);
        rx_line = v;
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
    endtask

    // narrow: bit value only at sample index 3, complement elsewhere
    task automatic send_frame(input logic [7:0] d, input logic stop, input bit narrow);
        for (int i = 0; i < 2; i++) do_tick(1'b1);
        for (int i = 0; i < 8; i++) do_tick(1'b0);
        for (int b = 0; b < 8; b++)
            for (int i = 0; i < 8; i++)
                do_tick((narrow && i != 3) ? ~d[b] : d[b]);
        for (int i = 0; i < 4; i++) do_tick(stop);
        v_at = rx_valid;
        @(negedge clk);
        v_nx = rx_valid;
        for (int i = 0; i < 4; i++) do_tick(1'b1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(rx_data == 8'h00 && !rx_valid && !err_overrun && !err_frame, "R1 reset",
            {rx_data, rx_valid, err_overrun, err_frame}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: idle line gives no word
        for (int i = 0; i < 24; i++) do_tick(1'b1);
        chk(vcnt == 0, "R2 idle no word", vcnt, 0);

        // vector table: R4 data, R5 single pulse, R6 frame flag, R7 overrun
        for (int k = 0; k < 5; k++) begin
            base = vcnt;
            host_busy = VEC[k][0];
            send_frame(VEC[k][9:2], VEC[k][1], 1'b0);
            host_busy = 1'b0;
            chk(vcnt == base + 1, "R5 one pulse per frame", vcnt - base, 1);
            chk(cap_data == VEC[k][9:2], "R4 data word", cap_data, VEC[k][9:2]);
            chk(cap_frm == ~VEC[k][1], "R6 frame flag", cap_frm, ~VEC[k][1]);
            chk(cap_ovr == VEC[k][0], "R7 overrun flag", cap_ovr, VEC[k][0]);
        end

        // R4: narrow bits expose sampling point and start alignment
        base = vcnt;
        send_frame(8'hC6, 1'b1, 1'b1);
        chk(vcnt == base + 1 && cap_data == 8'hC6, "R4 mid-bit sampling", cap_data, 8'hC6);
        chk(v_at == 1'b1 && v_nx == 1'b0, "R5 pulse timing", {v_at, v_nx}, 2'b10);

        // R8: flags persist in idle, then clear on start edge
        host_busy = 1'b1;
        send_frame(8'h5E, 1'b0, 1'b0);
        host_busy = 1'b0;
        for (int i = 0; i < 10; i++) do_tick(1'b1);
        chk(err_frame && err_overrun, "R8 flags hold", {err_frame, err_overrun}, 2'b11);
        do_tick(1'b0);
        chk(!err_frame && !err_overrun, "R8 flags clear on start", {err_frame, err_overrun}, 2'b00);
        for (int i = 0; i < 3; i++) do_tick(1'b1);

        // R3 and R10: false starts of two and three low samples
        base = vcnt;
        do_tick(1'b0); do_tick(1'b0); do_tick(1'b1);
        for (int i = 0; i < 12; i++) do_tick(1'b1);
        do_tick(1'b0); do_tick(1'b0); do_tick(1'b0); do_tick(1'b1);
        for (int i = 0; i < 100; i++) do_tick(1'b1);
        chk(vcnt == base, "R3 false start no word", vcnt - base, 0);
        chk(rx_data == 8'h5E, "R10 data held", rx_data, 8'h5E);
        send_frame(8'h5A, 1'b1, 1'b1);
        chk(vcnt == base + 1 && cap_data == 8'h5A, "R3 frame after false start", cap_data, 8'h5A);

        // R9: line low without ticks has no effect
        base = vcnt;
        @(negedge clk);
        rx_line = 1'b0;
        repeat (120) @(negedge clk);
        rx_line = 1'b1;
        for (int i = 0; i < 12; i++) do_tick(1'b1);
        chk(vcnt == base && !err_frame, "R9 no tick no effect", vcnt - base, 0);
        chk(rx_data == 8'h5A, "R10 data held after no-tick", rx_data, 8'h5A);

        // R1: reset in mid-frame returns to idle values
        for (int i = 0; i < 20; i++) do_tick(1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(rx_data == 8'h00 && !rx_valid && !err_frame && !err_overrun, "R1 reset mid-frame",
            rx_data, 0);
        rst_n = 1'b1;
        base = vcnt;
        send_frame(8'h96, 1'b1, 1'b0);
        chk(vcnt == base + 1 && cap_data == 8'h96, "R1 frame after reset", cap_data, 8'h96);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule